// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Sticky Overflow

This block is the arithmetic core of a multiply-accumulate engine. Each cycle in which the valid strobe is high, it takes two 32-bit operands, the current values of a two-word accumulator and a 4-bit operation code. It registers the new accumulator words one cycle later. The surrounding logic reads the accumulator from its storage, presents it here, and writes the results back. Register selection, immediate fetch and hazard handling stay with that logic.

Ten operations are supported. There is a full 32x32 multiply added into a 64-bit accumulator, which is handled as two 32-bit words with an explicit carry between them. There are byte and halfword multiplies added into the low accumulator word. A dual-halfword operation adds two halfword products into the low word in a single step. A dual-halfword squaring operation writes two independent squares. Each kind comes in a signed and an unsigned form.

Overflow is judged from sign bits only. Any overflow sets a sticky flag, and no accumulate operation ever clears it. The flag is cleared only by a dedicated synchronous clear input.

Top module: `mac_sticky_unit`

## Requirements
- R1: A cycle with `in_valid` high produces `out_valid` high on the next cycle, with the results of that operation on `res_hi`/`res_lo`. A cycle with `in_valid` low produces `out_valid` low on the next cycle.
- R2: Code 0 (full signed): {res_hi,res_lo} = {acc_hi,acc_lo} + the sign-extended 64-bit product of `opnd_a` and `opnd_b`, taken modulo 2^64.
- R3: Code 1 (full unsigned): the same as R2, with both operands zero-extended.
- R4: In the full operations, a carry passes into the high word when the low-word sum is smaller than one of its addends.
- R5: A full operation flags overflow when bit 31 of `acc_hi` equals bit 63 of the product and bit 31 of `res_hi` differs from it.
- R6: Codes 2 and 3 (byte signed and byte unsigned) multiply bits [7:0] of both operands, sign-extended for code 2 and zero-extended for code 3. The 32-bit product is added to `acc_lo` to give `res_lo`, and `res_hi` = `acc_hi`.
- R7: Codes 4 and 5 (half signed and half unsigned) work as in R6, using bits [15:0].
- R8: Codes 6 and 7 (dual signed and dual unsigned): res_lo = acc_lo + a[15:0]*b[15:0] + a[31:16]*b[31:16], with each field extended by signedness, and res_hi = acc_hi.
- R9: A single-word operation (codes 2 to 7) flags overflow when bit 31 of `acc_lo` equals bit 31 of the addend and bit 31 of `res_lo` differs from it. For codes 6 and 7 the addend is the 32-bit wrapped sum of the two products.
- R10: Codes 8 and 9 (square signed and square unsigned): res_lo = a[15:0]², res_hi = a[31:16]², with each field extended by signedness. `opnd_b` and the accumulator inputs have no effect, and no overflow is flagged.
- R11: `ovf_sticky` goes high on the cycle after a flagged overflow and stays high through any later operation. `clr_ovf` clears it on the next cycle and wins over an overflow in the same cycle.
- R12: Results hold while `in_valid` is low. Codes 10 to 15 return res_hi = acc_hi and res_lo = acc_lo and leave the flag unchanged.
- R13: After reset, `out_valid`, `res_hi`, `res_lo` and `ovf_sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_ovf | input | 1 | Synchronous clear of the sticky overflow flag |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation code (0 to 9) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| acc_hi | input | 32 | Current high accumulator word |
| acc_lo | input | 32 | Current low accumulator word |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| res_hi | output | 32 | New high word (or high-half square) |
| res_lo | output | 32 | New low word (or low-half square) |
| ovf_sticky | output | 1 | Sticky overflow flag |

## Verification
Negative-times-positive and all-ones unsigned operands separate the signed products from the unsigned ones. A low accumulator word of all ones exercises the carry into the high word. Field values with the top bit set (0xF0 bytes, 0x8000 halves) show whether sign extension or zero extension was applied. Accumulators placed just below the signed limit show where the sign rule trips the flag. Square operations are run with two different second operands to show that the second operand is ignored, and an idle stretch plus an unused code show that the results and the flag hold.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = WORD_W / 2;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned OP_W   = 4;
    localparam int unsigned DBL_W  = 2 * WORD_W;

    typedef enum logic [OP_W-1:0] {
        OP_FULL_S = 4'd0,
        OP_FULL_U = 4'd1,
        OP_BYTE_S = 4'd2,
        OP_BYTE_U = 4'd3,
        OP_HALF_S = 4'd4,
        OP_HALF_U = 4'd5,
        OP_DUAL_S = 4'd6,
        OP_DUAL_U = 4'd7,
        OP_SQR_S  = 4'd8,
        OP_SQR_U  = 4'd9
    } mac_op_e;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
        logic              ovf;
    } mac_state_t;
endpackage

// File: rtl/mac_ext_mul.sv
module mac_ext_mul #(
    parameter int unsigned IN_W  = 16,
    parameter int unsigned OUT_W = 32
) (
    input  logic [IN_W-1:0]  fld_a,
    input  logic [IN_W-1:0]  fld_b,
    input  logic             is_signed,
    output logic [OUT_W-1:0] prod
);
    localparam int unsigned EXT_W = OUT_W - IN_W;

    logic [OUT_W-1:0] wide_a;
    logic [OUT_W-1:0] wide_b;

    always_comb begin
        wide_a = {{EXT_W{is_signed & fld_a[IN_W-1]}}, fld_a};
        wide_b = {{EXT_W{is_signed & fld_b[IN_W-1]}}, fld_b};
        // modular product: the low OUT_W bits are exact for both signednesses
        prod   = wide_a * wide_b;
    end

    generate
        if (OUT_W > 2 * IN_W) begin : g_upper_chk
            always_comb begin
                if (!is_signed)
                    AST_UNSIGNED_TOP_CLEAR: assert (prod[OUT_W-1:2*IN_W] == '0); // R6
            end
        end
    endgenerate
endmodule

// File: rtl/mac_word_add.sv
module mac_word_add #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] add_a,
    input  logic [W-1:0] add_b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         ovf
);
    always_comb begin
        sum = add_a + add_b + {{(W-1){1'b0}}, cin};
        ovf = (add_a[W-1] == add_b[W-1]) && (sum[W-1] != add_b[W-1]);
    end
endmodule

// File: rtl/mac_sticky_unit.sv
module mac_sticky_unit
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_ovf,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [WORD_W-1:0] acc_hi,
    input  logic [WORD_W-1:0] acc_lo,
    output logic              out_valid,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo,
    output logic              ovf_sticky
);
    localparam int unsigned N_LANES = WORD_W / HALF_W;

    mac_state_t        cur_q, nxt_d;
    mac_op_e           op;
    logic              sgn;
    logic              is_sqr;
    logic [DBL_W-1:0]  p_full;
    logic [WORD_W-1:0] p_byte;
    logic [WORD_W-1:0] p_half [N_LANES];
    logic [HALF_W-1:0] lane_b [N_LANES];
    logic [WORD_W-1:0] add_lo;
    logic [WORD_W-1:0] sum_lo, sum_hi;
    logic              ovf_lo, ovf_hi;
    logic              carry_lo;
    logic              ov_event;

    always_comb begin
        op     = mac_op_e'(op_sel);
        sgn    = ~op_sel[0];
        is_sqr = (op == OP_SQR_S) || (op == OP_SQR_U);
    end

    mac_ext_mul #(.IN_W(WORD_W), .OUT_W(DBL_W)) u_mul_full (
        .fld_a(opnd_a), .fld_b(opnd_b), .is_signed(sgn), .prod(p_full));

    mac_ext_mul #(.IN_W(BYTE_W), .OUT_W(WORD_W)) u_mul_byte (
        .fld_a(opnd_a[BYTE_W-1:0]), .fld_b(opnd_b[BYTE_W-1:0]),
        .is_signed(sgn), .prod(p_byte));

    // halfword lanes are shared by the dual and square operations
    generate
        for (genvar l = 0; l < N_LANES; l++) begin : g_lane
            always_comb
                lane_b[l] = is_sqr ? opnd_a[l*HALF_W +: HALF_W]
                                   : opnd_b[l*HALF_W +: HALF_W];
            mac_ext_mul #(.IN_W(HALF_W), .OUT_W(WORD_W)) u_mul_half (
                .fld_a(opnd_a[l*HALF_W +: HALF_W]), .fld_b(lane_b[l]),
                .is_signed(sgn), .prod(p_half[l]));
        end
    endgenerate

    always_comb begin
        unique case (op)
            OP_FULL_S, OP_FULL_U: add_lo = p_full[WORD_W-1:0];
            OP_BYTE_S, OP_BYTE_U: add_lo = p_byte;
            OP_HALF_S, OP_HALF_U: add_lo = p_half[0];
            OP_DUAL_S, OP_DUAL_U: add_lo = p_half[0] + p_half[1];
            default:              add_lo = '0;
        endcase
    end

    mac_word_add #(.W(WORD_W)) u_add_lo (
        .add_a(acc_lo), .add_b(add_lo), .cin(1'b0), .sum(sum_lo), .ovf(ovf_lo));

    always_comb carry_lo = (sum_lo < acc_lo) || (sum_lo < add_lo);

    mac_word_add #(.W(WORD_W)) u_add_hi (
        .add_a(acc_hi), .add_b(p_full[DBL_W-1:WORD_W]), .cin(carry_lo),
        .sum(sum_hi), .ovf(ovf_hi));

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = in_valid;
        ov_event  = 1'b0;
        if (in_valid) begin
            unique case (op)
                OP_FULL_S, OP_FULL_U: begin
                    nxt_d.hi = sum_hi;
                    nxt_d.lo = sum_lo;
                    ov_event = ovf_hi;
                end
                OP_BYTE_S, OP_BYTE_U, OP_HALF_S, OP_HALF_U,
                OP_DUAL_S, OP_DUAL_U: begin
                    nxt_d.hi = acc_hi;
                    nxt_d.lo = sum_lo;
                    ov_event = ovf_lo;
                end
                OP_SQR_S, OP_SQR_U: begin
                    nxt_d.hi = p_half[1];
                    nxt_d.lo = p_half[0];
                end
                default: begin
                    nxt_d.hi = acc_hi;
                    nxt_d.lo = acc_lo;
                end
            endcase
        end
        nxt_d.ovf = clr_ovf ? 1'b0 : (cur_q.ovf | ov_event);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_valid  = cur_q.vld;
    assign res_hi     = cur_q.hi;
    assign res_lo     = cur_q.lo;
    assign ovf_sticky = cur_q.ovf;

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_hi) && $stable(res_lo))); // R12
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && !clr_ovf) |=> ovf_sticky); // R11
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ovf |=> !ovf_sticky); // R11
    AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !ovf_sticky) |=> !ovf_sticky); // R12
    AST_SQR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_sqr && !ovf_sticky) |=> !ovf_sticky); // R10
endmodule

// File: tb/test_mac_sticky_unit.sv
module test_mac_sticky_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_ovf = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, acc_hi = '0, acc_lo = '0;
    logic        out_valid, ovf_sticky;
    logic [31:0] res_hi, res_lo;

    int total = 0;
    int bad = 0;
    bit exp_ovf = 1'b0;

    always #2 clk = ~clk;

    mac_sticky_unit i_mac_sticky_unit (
        .clk(clk), .rst_n(rst_n), .clr_ovf(clr_ovf), .in_valid(in_valid),
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .out_valid(out_valid),
        .res_hi(res_hi), .res_lo(res_lo), .ovf_sticky(ovf_sticky));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ext(input logic [15:0] f, input int w, input bit s);
        logic [31:0] r;
        r = {16'b0, f};
        if (w == 8) r = s ? {{24{f[7]}}, f[7:0]} : {24'b0, f[7:0]};
        else if (s) r = {{16{f[15]}}, f};
        return r;
    endfunction

    task automatic model(input logic [3:0] op, input logic [31:0] a, b, ah, al,
                         output logic [31:0] rh, rl, output bit ev);
        logic [63:0] ax, bx, p, s;
        logic [31:0] ad;
        bit sg;
        sg = !op[0];
        ev = 0; rh = ah; rl = al;
        if (op <= 4'd1) begin
            ax = sg ? {{32{a[31]}}, a} : {32'b0, a};
            bx = sg ? {{32{b[31]}}, b} : {32'b0, b};
            p = ax * bx;
            s = {ah, al} + p;
            rh = s[63:32]; rl = s[31:0];
            ev = (ah[31] == p[63]) && (rh[31] != p[63]);
        end else if (op <= 4'd7) begin
            if (op <= 4'd3) ad = ext(a[15:0], 8, sg) * ext(b[15:0], 8, sg);
            else if (op <= 4'd5) ad = ext(a[15:0], 16, sg) * ext(b[15:0], 16, sg);
            else ad = ext(a[15:0], 16, sg) * ext(b[15:0], 16, sg)
                    + ext(a[31:16], 16, sg) * ext(b[31:16], 16, sg);
            rl = al + ad;
            ev = (al[31] == ad[31]) && (rl[31] != ad[31]);
        end else if (op <= 4'd9) begin
            rl = ext(a[15:0], 16, sg) * ext(a[15:0], 16, sg);
            rh = ext(a[31:16], 16, sg) * ext(a[31:16], 16, sg);
        end
    endtask

    task automatic run_op(input string req, input logic [3:0] op,
                          input logic [31:0] a, b, ah, al, input bit clr);
        logic [31:0] eh, el;
        bit ev;
        model(op, a, b, ah, al, eh, el, ev);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; acc_hi = ah; acc_lo = al;
        in_valid = 1'b1; clr_ovf = clr;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; clr_ovf = 1'b0;
        exp_ovf = clr ? 1'b0 : (exp_ovf | ev);
        check({req, " valid (R1)"}, {31'b0, out_valid}, 32'd1);
        check({req, " hi"}, res_hi, eh);
        check({req, " lo"}, res_lo, el);
        check({req, " ovf"}, {31'b0, ovf_sticky}, {31'b0, exp_ovf});
    endtask

    task automatic t_reset;
        check("R13 valid", {31'b0, out_valid}, 0);
        check("R13 hi", res_hi, 0);
        check("R13 lo", res_lo, 0);
        check("R13 ovf", {31'b0, ovf_sticky}, 0);
    endtask

    task automatic t_full;
        run_op("R2 neg*pos", 4'd0, 32'd3, 32'hFFFF_FFFB, 32'd0, 32'd100, 0);
        run_op("R2 neg*neg", 4'd0, 32'h8000_0000, 32'h8000_0000, 32'h1, 32'h2, 0);
        run_op("R3 max*max", 4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h10, 32'h5, 0);
        run_op("R4 carry", 4'd0, 32'd1, 32'd1, 32'h0000_0007, 32'hFFFF_FFFF, 0);
        run_op("R4 carry_u", 4'd1, 32'h0001_0000, 32'h0001_0001, 32'h1, 32'hFFFF_0000, 0);
    endtask

    task automatic t_full_ovf;
        run_op("R5 full_ovf", 4'd0, 32'h0001_0000, 32'h0001_0000, 32'h7FFF_FFFF, 32'h0, 0);
        check("R5 flag set", {31'b0, ovf_sticky}, 32'd1);
        run_op("R11 clear", 4'hC, 32'h0, 32'h0, 32'h0, 32'h0, 1);
    endtask

    task automatic t_byte_half;
        run_op("R6 byte_s", 4'd2, 32'h1234_56F0, 32'hAB00_0003, 32'hDEAD_BEEF, 32'd1000, 0);
        run_op("R6 byte_u", 4'd3, 32'h1234_56F0, 32'hAB00_0003, 32'hDEAD_BEEF, 32'd1000, 0);
        run_op("R7 half_s", 4'd4, 32'hFFFF_8000, 32'h0000_0002, 32'h5, 32'h0002_0000, 0);
        run_op("R7 half_u", 4'd5, 32'hFFFF_8000, 32'h0000_0002, 32'h5, 32'h0002_0000, 0);
    endtask

    task automatic t_dual;
        run_op("R8 dual_s", 4'd6, 32'hFFFE_0003, 32'h0004_FFFF, 32'h9, 32'd50, 0);
        run_op("R8 dual_u", 4'd7, 32'hFFFE_0003, 32'h0004_FFFF, 32'h9, 32'd50, 0);
    endtask

    task automatic t_word_ovf;
        run_op("R9 half_ovf", 4'd4, 32'h0000_7FFF, 32'h0000_7FFF, 32'h0, 32'h7FFF_FFF0, 0);
        check("R9 flag set", {31'b0, ovf_sticky}, 32'd1);
        run_op("R11 keep", 4'd2, 32'd2, 32'd3, 32'h0, 32'h0, 0);
        check("R11 stays", {31'b0, ovf_sticky}, 32'd1);
        run_op("R11 clr_vs_set", 4'd6, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h0, 32'h7000_0000, 1);
        check("R11 clear wins", {31'b0, ovf_sticky}, 32'd0);
    endtask

    task automatic t_square;
        logic [31:0] h1, l1;
        run_op("R10 sqr_s b1", 4'd8, 32'hFFFF_0003, 32'h1234_5678, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0);
        h1 = res_hi; l1 = res_lo;
        check("R10 lo=9", l1, 32'd9);
        check("R10 hi=1", h1, 32'd1);
        run_op("R10 sqr_s b2", 4'd8, 32'hFFFF_0003, 32'hFFFF_FFFF, 32'h0, 32'h0, 0);
        check("R10 b ignored", res_hi ^ h1 | res_lo ^ l1, 32'd0);
        run_op("R10 sqr_u", 4'd9, 32'hFFFF_0003, 32'h0, 32'h0, 32'h0, 0);
        check("R10 hi_u", res_hi, 32'hFFFE_0001);
    endtask

    task automatic t_idle;
        logic [31:0] h0, l0;
        run_op("R12 unused", 4'hE, 32'h5, 32'h6, 32'hCAFE_0001, 32'h0BAD_F00D, 0);
        h0 = res_hi; l0 = res_lo;
        @(negedge clk);
        opnd_a = 32'h0001_0000; opnd_b = 32'h0001_0000; acc_hi = 32'h7FFF_FFFF; op_sel = 4'd0;
        repeat (3) @(negedge clk);
        check("R12 hold hi", res_hi, h0);
        check("R12 hold lo", res_lo, l0);
        check("R12 idle valid", {31'b0, out_valid}, 0);
        check("R12 idle ovf", {31'b0, ovf_sticky}, {31'b0, exp_ovf});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_full_ovf();
        t_byte_half();
        t_dual();
        t_word_ovf();
        t_square();
        t_idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule